// File: doc/BRIEF.md
# Flash ECC Fault Status Flags

This block keeps two sticky status flags that report the outcome of error-correcting reads from a flash array. One flag records a corrected single-bit fault. The other records an uncorrectable double-bit fault. The ECC decoder gives the block a read-done strobe and two fault indications. A busy input shows that a flash command is running on the block being read. A configuration bit can mask single-bit fault reporting.

A read that arrives while a command is busy is an access collision. The block reports it by raising both flags in the same cycle. A genuine ECC result never produces that pair, so software can tell a collision apart from a real fault. A bus write clears the flags one at a time: writing 1 to a bit position clears that flag. Each flag is gated by its own enable bit to form a level interrupt request.

Top module: `fecc_flags`

## Requirements
- R1: While rst_ni is low, both flags are cleared asynchronously, so status_o reads 8'h00 and irq_o reads 2'b00.
- R2: A completed read (rd_done_i=1, blk_busy_i=0) with ecc_dbe_i=1 sets the double-fault flag, status_o bit 1, on the next rising clock edge.
- R3: A completed read with ecc_sbe_i=1, ecc_dbe_i=0 and blk_busy_i=0 sets the single-fault flag, status_o bit 0, only when ign_sbe_i=0. When ign_sbe_i=1 the single-fault flag is left unchanged.
- R4: If ecc_sbe_i and ecc_dbe_i are both high on a completed read without a collision, only the double-fault flag is set.
- R5: When rd_done_i=1 and blk_busy_i=1 (a collision), both flags are set together. This holds whatever the values of ecc_sbe_i, ecc_dbe_i and ign_sbe_i.
- R6: When wr_en_i=1, a 1 in wr_data_i bit 1 clears the double-fault flag and a 1 in wr_data_i bit 0 clears the single-fault flag. A 0 in either bit leaves that flag unchanged.
- R7: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R8: status_o bits 7:2 always read zero.
- R9: irq_o[0] equals the single-fault flag ANDed with irq_en_i[0], and irq_o[1] equals the double-fault flag ANDed with irq_en_i[1]. Both are combinational.
- R10: While rd_done_i is low and there is no clearing write, the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_done_i | input | 1 | Array read completed this cycle |
| ecc_sbe_i | input | 1 | Single-bit fault detected and corrected |
| ecc_dbe_i | input | 1 | Double-bit fault detected |
| blk_busy_i | input | 1 | Flash command is running on the targeted block |
| ign_sbe_i | input | 1 | Mask single-bit fault reporting |
| wr_en_i | input | 1 | Status write strobe |
| wr_data_i | input | 8 | Write data; a 1 in bit 0 or bit 1 clears that flag |
| irq_en_i | input | 2 | Interrupt enables: bit 0 for single-fault, bit 1 for double-fault |
| status_o | output | 8 | Flags: bit 1 is double-fault, bit 0 is single-fault, the rest are zero |
| irq_o | output | 2 | Level interrupt requests |

## Verification
Each flag register updates on the rising edge that samples the read or write strobe, so a set or a clear shows on status_o one edge after the stimulus. irq_o follows the flags and the enables with no added delay. The bench changes its inputs on falling edges, holds each strobe for exactly one rising edge, and samples on the next falling edge. That way each result is read in the cycle in which it is first due, and no later. For an enable change alone, the bench samples irq_o on the same falling edge without waiting for a clock edge.

// File: rtl/fecc_pkg.sv
package fecc_pkg;
  localparam int unsigned NUM_FLAGS  = 2;
  localparam int unsigned STAT_W     = 8;
  localparam int unsigned SGL_IDX    = 0;
  localparam int unsigned DBL_IDX    = 1;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/fecc_event.sv
module fecc_event
  import fecc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rd_done_i,
  input  logic      ecc_sbe_i,
  input  logic      ecc_dbe_i,
  input  logic      blk_busy_i,
  input  logic      ign_sbe_i,
  output flag_vec_t set_o
);
  logic collide, dbl_hit, sgl_hit;

  always_comb begin
    collide = rd_done_i & blk_busy_i;
    dbl_hit = rd_done_i & ~blk_busy_i & ecc_dbe_i;
    // double wins over single; mask only affects a real single fault
    sgl_hit = rd_done_i & ~blk_busy_i & ~ecc_dbe_i & ecc_sbe_i & ~ign_sbe_i;
    set_o          = '0;
    set_o[DBL_IDX] = collide | dbl_hit;
    set_o[SGL_IDX] = collide | sgl_hit;
  end

  // R5
  pair_only_on_collision_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_o[DBL_IDX] && set_o[SGL_IDX]) |-> (rd_done_i && blk_busy_i));

  // R3
  masked_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ign_sbe_i && !blk_busy_i) |-> !set_o[SGL_IDX]);
endmodule

// File: rtl/fecc_flag_cell.sv
module fecc_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;   // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);

  // R6
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/fecc_flags.sv
module fecc_flags
  import fecc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_done_i,
  input  logic                 ecc_sbe_i,
  input  logic                 ecc_dbe_i,
  input  logic                 blk_busy_i,
  input  logic                 ign_sbe_i,
  input  logic                 wr_en_i,
  input  logic [STAT_W-1:0]    wr_data_i,
  input  logic [NUM_FLAGS-1:0] irq_en_i,
  output logic [STAT_W-1:0]    status_o,
  output logic [NUM_FLAGS-1:0] irq_o
);
  flag_vec_t set_v, clr_v, flag_v;

  fecc_event u_event (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_done_i  (rd_done_i),
    .ecc_sbe_i  (ecc_sbe_i),
    .ecc_dbe_i  (ecc_dbe_i),
    .blk_busy_i (blk_busy_i),
    .ign_sbe_i  (ign_sbe_i),
    .set_o      (set_v)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    assign clr_v[g] = wr_en_i & wr_data_i[g];
    fecc_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .en_i   (irq_en_i[g]),
      .flag_o (flag_v[g]),
      .irq_o  (irq_o[g])
    );
  end

  always_comb begin
    status_o                = '0;
    status_o[NUM_FLAGS-1:0] = flag_v;
  end

  // R5
  collision_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_i && blk_busy_i) |=> (status_o[DBL_IDX] && status_o[SGL_IDX]));

  // R2
  dbl_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done_i && ecc_dbe_i) |=> status_o[DBL_IDX]);
endmodule

// File: tb/fecc_flags_tb_top.sv
module fecc_flags_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_done_i = 0, ecc_sbe_i = 0, ecc_dbe_i = 0, blk_busy_i = 0, ign_sbe_i = 0;
  logic wr_en_i = 0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] irq_en_i = '0;
  logic [7:0] status_o;
  logic [1:0] irq_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  fecc_flags dut_i (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-edge stimulus, result sampled at the following falling edge
  task automatic step(logic rd, logic sbe, logic dbe, logic busy, logic ign,
                      logic we, logic [7:0] wd);
    rd_done_i = rd; ecc_sbe_i = sbe; ecc_dbe_i = dbe; blk_busy_i = busy;
    ign_sbe_i = ign; wr_en_i = we; wr_data_i = wd;
    @(negedge clk_i);
    rd_done_i = 0; ecc_sbe_i = 0; ecc_dbe_i = 0; blk_busy_i = 0;
    wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic clr_all();
    step(0, 0, 0, 0, 0, 1, 8'h03);
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 8'h00);
    chk("R1 irq", {6'd0, irq_o}, 8'h00);
  endtask

  task automatic t_double();
    step(1, 0, 1, 0, 0, 0, 8'h00);
    chk("R2 dbl set", status_o, 8'h02);
    clr_all();
  endtask

  task automatic t_single();
    step(1, 1, 0, 0, 0, 0, 8'h00);
    chk("R3 sgl set", status_o, 8'h01);
    clr_all();
    step(1, 1, 0, 0, 1, 0, 8'h00);
    chk("R3 sgl masked", status_o, 8'h00);
  endtask

  task automatic t_both_ecc();
    step(1, 1, 1, 0, 0, 0, 8'h00);
    chk("R4 dbl priority", status_o, 8'h02);
    clr_all();
  endtask

  task automatic t_collision();
    step(1, 0, 0, 1, 1, 0, 8'h00);
    chk("R5 collision masked cfg", status_o, 8'h03);
    clr_all();
    step(1, 1, 1, 1, 0, 0, 8'h00);
    chk("R5 collision ecc", status_o, 8'h03);
  endtask

  task automatic t_clear();
    step(0, 0, 0, 0, 0, 1, 8'hFC);
    chk("R6 write0 no effect", status_o, 8'h03);
    step(0, 0, 0, 0, 0, 1, 8'h01);
    chk("R6 clear sgl", status_o, 8'h02);
    step(0, 0, 0, 0, 0, 1, 8'h02);
    chk("R6 clear dbl", status_o, 8'h00);
    step(0, 1, 1, 1, 0, 0, 8'h00);
    chk("R10 no strobe", status_o, 8'h00);
  endtask

  task automatic t_race();
    step(1, 0, 1, 0, 0, 1, 8'h02);
    chk("R7 set beats clear", status_o, 8'h02);
    step(1, 1, 0, 0, 0, 1, 8'h03);
    chk("R7 sgl kept dbl cleared", status_o, 8'h01);
    chk("R8 upper zero", status_o & 8'hFC, 8'h00);
    clr_all();
  endtask

  task automatic t_irq();
    step(1, 0, 0, 1, 0, 0, 8'h00);
    irq_en_i = 2'b00; #1;
    chk("R9 irq off", {6'd0, irq_o}, 8'h00);
    irq_en_i = 2'b01; #1;
    chk("R9 irq sgl", {6'd0, irq_o}, 8'h01);
    irq_en_i = 2'b10; #1;
    chk("R9 irq dbl", {6'd0, irq_o}, 8'h02);
    step(0, 0, 0, 0, 0, 1, 8'h02);
    irq_en_i = 2'b11; #1;
    chk("R9 irq after clear", {6'd0, irq_o}, 8'h01);
  endtask

  initial begin
    fork
      begin
        @(negedge clk_i);
        t_reset();
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_double();
        t_single();
        t_both_ecc();
        t_collision();
        t_clear();
        t_race();
        t_irq();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule